// File: doc/BRIEF.md
# Glitch-Safe System Clock Divider

This block turns a free-running source clock into a system clock at a power-of-two fraction of the source rate. A 3-bit ratio code N gives an output period of 2^N source periods: code 0 sends the source straight through, and code 7 divides by 128. The source never stops, so the output never stops either.

Software reaches the block over a simple word-wide register port. It writes a new ratio into a control word, where the ratio only waits. The output moves to that ratio after a two-step commit: a 0 and then a 1 written to a separate commit register. The switch waits until every candidate clock is in its low phase at a common period boundary. Because of this, no high or low phase at the output is ever shorter than half a period of the faster of the two ratios. The control word also holds a 6-bit trim code. The block only stores this code and drives it out to the oscillator, and it does nothing else with it.

Top module: `clkdiv_sys`

## Requirements
- R1: After reset the ratio code is 4, so the output period is 16 source periods. The trim code equals the TRIM_RESET parameter, and the commit register reads 0.
- R2: Once committed, ratio code N gives an output period of exactly 2^N source periods. Code 0 gives an output that equals the source clock.
- R3: Writing a ratio code to the control word changes only the pending value. The output period stays the same until a commit.
- R4: Writing 0 and then 1 to the commit register applies the pending ratio at the next 128-cycle boundary of the internal counter.
- R5: A write of 1 to the commit register that does not directly follow a write of 0 leaves the output ratio unchanged. This covers a 1 written just after reset and a second 1 written after a commit.
- R6: The control word sits at byte offset 0x20. The ratio code is in bits 3:1 and the trim code is in bits 21:16. Reading it returns the pending values, and every other bit reads as 0. The commit register sits at 0x24, and its bit 0 reads back the last value written to it.
- R7: trim_out follows the trim field from the cycle after a control-word write, and changing it has no effect on the output clock.
- R8: A ratio change happens only while the output is low, at the point where the counter wraps. No high or low phase around a change is shorter than half a period of the faster ratio.
- R9: The output keeps toggling under every ratio. Over 2000 source cycles at ratio 7 it shows at least 15 rising edges.
- R10: Writes to any address other than 0x20 and 0x24 are ignored. This includes misaligned addresses such as 0x21 and 0x25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one source cycle per write |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| clk_out | output | 1 | Divided system clock |
| trim_out | output | TRIM_W | Stored trim code for the oscillator |

## Verification
The bench commits every ratio code once, in an order that makes both large upward jumps and large downward jumps. It tracks the narrowest phase of clk_out across each switch. A design that switched in the middle of a phase would show a sliver far shorter than half the faster period. The bench also sends a bare 1, a repeated 1 and misaligned commit writes. A design without correct arming logic would change the output period after one of these, and the bench measures that period. Finally, it writes all ones to the control word to catch reserved bits that leak into reads and a trim code that disturbs the clock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   // Byte offsets of the two registers; accesses are whole aligned words.
   localparam int unsigned CTRL_OFS = 32'h20;
   localparam int unsigned UEN_OFS  = 32'h24;
   // Field positions inside the control word.
   localparam int unsigned DIV_LSB  = 1;
   localparam int unsigned TRIM_LSB = 16;
   localparam int unsigned DATA_W   = 32;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
   import clkdiv_pkg::*;
#(
   parameter int DIV_W      = 3,
   parameter int TRIM_W     = 6,
   parameter int ADDR_W     = 12,
   parameter int RESET_DIV  = 4,
   parameter int TRIM_RESET = 'h25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DIV_W-1:0]  pend_div,
   output logic [TRIM_W-1:0] trim,
   output logic              commit
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] UEN_A  = ADDR_W'(UEN_OFS);

   if (DIV_LSB + DIV_W > TRIM_LSB) begin : g_bad_div
      $error("ratio field overlaps trim field");
   end
   if (TRIM_LSB + TRIM_W > DATA_W) begin : g_bad_trim
      $error("trim field exceeds data word");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("address too narrow for register offsets");
   end

   logic ctrl_hit, uen_hit;
   logic uen_bit, armed;

   assign ctrl_hit = (addr == CTRL_A);
   assign uen_hit  = (addr == UEN_A);

   // A 1 commits only if the previous commit-register write was a 0.
   assign commit = we && uen_hit && wdata[0] && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_div <= DIV_W'(RESET_DIV);
         trim     <= TRIM_W'(TRIM_RESET);
         uen_bit  <= 1'b0;
         armed    <= 1'b0;
      end else if (we) begin
         if (ctrl_hit) begin
            pend_div <= wdata[DIV_LSB +: DIV_W];
            trim     <= wdata[TRIM_LSB +: TRIM_W];
         end
         if (uen_hit) begin
            uen_bit <= wdata[0];
            armed   <= ~wdata[0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (ctrl_hit) begin
         rdata[DIV_LSB +: DIV_W]   = pend_div;
         rdata[TRIM_LSB +: TRIM_W] = trim;
      end else if (uen_hit) begin
         rdata[0] = uen_bit;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
   parameter int DIV_W     = 3,
   parameter int RESET_DIV = 4,
   localparam int NRAT     = 2 ** DIV_W,
   localparam int CNT_W    = NRAT - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [DIV_W-1:0] new_div,
   output logic [CNT_W-1:0] cnt,
   output logic             apply_pend,
   output logic [DIV_W-1:0] act_next,
   output logic [DIV_W-1:0] act_sel,
   output logic             clk_out
);
   if (DIV_W < 1 || DIV_W > 5) begin : g_bad_w
      $error("DIV_W must lie in 1..5");
   end
   if (RESET_DIV >= NRAT) begin : g_bad_rst
      $error("RESET_DIV out of range");
   end

   logic [DIV_W-1:0] stage;
   logic             wrap;

   assign wrap = &cnt;

   // Rising-edge side: shared counter, staged ratio, boundary hand-over.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         stage      <= DIV_W'(RESET_DIV);
         apply_pend <= 1'b0;
         act_next   <= DIV_W'(RESET_DIV);
      end else begin
         cnt <= cnt + CNT_W'(1);
         if (commit) stage <= new_div;
         if (commit)    apply_pend <= 1'b1;
         else if (wrap) apply_pend <= 1'b0;
         if (apply_pend && wrap) act_next <= stage;
      end
   end

   // Falling-edge side: the select moves half a cycle after the wrap,
   // when the source and every counter tap are low.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) act_sel <= DIV_W'(RESET_DIV);
      else        act_sel <= act_next;
   end

   logic [NRAT-1:0] taps;
   for (genvar k = 0; k < NRAT; k++) begin : g_tap
      if (k == 0) begin : g_pass
         assign taps[k] = clk;
      end else begin : g_div
         assign taps[k] = cnt[k-1];
      end
   end

   assign clk_out = taps[act_sel];
endmodule

// File: rtl/clkdiv_sys.sv
module clkdiv_sys
   import clkdiv_pkg::*;
#(
   parameter int DIV_W      = 3,
   parameter int TRIM_W     = 6,
   parameter int ADDR_W     = 12,
   parameter int RESET_DIV  = 4,
   parameter int TRIM_RESET = 'h25
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              clk_out,
   output logic [TRIM_W-1:0] trim_out
);
   localparam int CNT_W = 2 ** DIV_W - 1;

   logic [DIV_W-1:0] pend_div;
   logic             commit;
   logic [CNT_W-1:0] cnt;
   logic             apply_pend;
   logic [DIV_W-1:0] act_next;
   logic [DIV_W-1:0] act_sel;

   clkdiv_regs #(
      .DIV_W(DIV_W), .TRIM_W(TRIM_W), .ADDR_W(ADDR_W),
      .RESET_DIV(RESET_DIV), .TRIM_RESET(TRIM_RESET)
   ) u_regs (
      .clk(clk_src), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .pend_div(pend_div),
      .trim(trim_out), .commit(commit)
   );

   clkdiv_core #(
      .DIV_W(DIV_W), .RESET_DIV(RESET_DIV)
   ) u_core (
      .clk(clk_src), .rst_n(rst_n), .commit(commit), .new_div(pend_div),
      .cnt(cnt), .apply_pend(apply_pend), .act_next(act_next),
      .act_sel(act_sel), .clk_out(clk_out)
   );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
   import clkdiv_pkg::*;
#(
   parameter int DIV_W  = 3,
   parameter int TRIM_W = 6,
   parameter int ADDR_W = 12,
   localparam int CNT_W = 2 ** DIV_W - 1
) (
   input logic              clk_src,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic [TRIM_W-1:0] trim_out,
   input logic              commit,
   input logic [CNT_W-1:0]  cnt,
   input logic              apply_pend,
   input logic [DIV_W-1:0]  act_next,
   input logic [DIV_W-1:0]  act_sel
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [31:0] LIVE =
      ((32'(2 ** DIV_W) - 32'd1) << DIV_LSB) |
      ((32'(2 ** TRIM_W) - 32'd1) << TRIM_LSB);

   // R9
   cnt_step_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
      $past(rst_n) |-> (cnt == $past(cnt) + CNT_W'(1)));

   // R4
   commit_arm_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
      commit |=> apply_pend);

   // R8
   next_at_wrap_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
      !$stable(act_next) |-> ($past(cnt) == '1));

   // R8
   sel_low_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
      !$stable(act_sel) |-> (cnt == '0));

   // R7
   trim_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
      !$stable(trim_out) |-> $past(reg_we && reg_addr == CTRL_A));

   // R6
   rsv_zero_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
      (reg_addr == CTRL_A) |-> ((reg_rdata & ~LIVE) == 32'd0));
endmodule

bind clkdiv_sys clkdiv_chk #(
   .DIV_W(DIV_W), .TRIM_W(TRIM_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk_src(clk_src), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .trim_out(trim_out), .commit(commit), .cnt(cnt),
   .apply_pend(apply_pend), .act_next(act_next), .act_sel(act_sel)
);

// File: tb/sim_clkdiv_sys.sv
`timescale 1ns/1ps
module sim_clkdiv_sys;
   localparam int TRIM_RST = 'h25;
   localparam real TCLK = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        clk_out;
   logic [5:0]  trim_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clkdiv_sys #(.TRIM_RESET(TRIM_RST)) u0 (
      .clk_src(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .clk_out(clk_out),
      .trim_out(trim_out)
   );

   // Narrowest phase monitor on the output clock.
   bit      mon_on = 1'b0, primed = 1'b0;
   realtime last_edge = 0, min_w = 1.0e9;
   int      rises = 0;
   always @(clk_out) begin
      if (mon_on) begin
         if (primed && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
         primed = 1'b1;
      end
      last_edge = $realtime;
      if (clk_out === 1'b1) rises++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic period(output realtime p);
      realtime t0;
      @(posedge clk_out); t0 = $realtime;
      @(posedge clk_out); p = $realtime - t0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic commit_ratio(input int n, input int trim);
      wr(12'h020, (32'(trim) << 16) | (32'(n) << 1));
      wr(12'h024, 32'd0);
      wr(12'h024, 32'd1);
   endtask

   task automatic t_reset;
      logic [31:0] d; realtime p;
      rd(12'h020, d);
      chk(d == 32'h0025_0008, "R1", "control word after reset", d, 32'h0025_0008);
      rd(12'h024, d);
      chk(d == 32'd0, "R1", "commit reg after reset", d, 0);
      chk(trim_out == 6'(TRIM_RST), "R1", "trim_out after reset", trim_out, TRIM_RST);
      period(p);
      chk(p == 16 * TCLK, "R1", "reset period ps", longint'(p * 1000), longint'(16 * TCLK * 1000));
   endtask

   task automatic t_pending;
      logic [31:0] d; realtime p;
      wr(12'h020, 32'h0025_0002);
      rd(12'h020, d);
      chk(d == 32'h0025_0002, "R3", "pending readback", d, 32'h0025_0002);
      wait_cyc(300); period(p);
      chk(p == 16 * TCLK, "R3", "period before commit ps", longint'(p * 1000), longint'(16 * TCLK * 1000));
   endtask

   task automatic t_bare_one;
      realtime p;
      wr(12'h024, 32'd1);
      wait_cyc(300); period(p);
      chk(p == 16 * TCLK, "R5", "period after bare 1 ps", longint'(p * 1000), longint'(16 * TCLK * 1000));
   endtask

   task automatic t_commit;
      realtime p; logic [31:0] d;
      wr(12'h024, 32'd0);
      wr(12'h024, 32'd1);
      rd(12'h024, d);
      chk(d == 32'd1, "R6", "commit reg readback", d, 1);
      wait_cyc(140); period(p);
      chk(p == 2 * TCLK, "R4", "period after commit ps", longint'(p * 1000), longint'(2 * TCLK * 1000));
   endtask

   task automatic t_second_one;
      realtime p;
      wr(12'h020, 32'h0025_000A);
      wr(12'h024, 32'd1);
      wait_cyc(300); period(p);
      chk(p == 2 * TCLK, "R5", "period after repeated 1 ps", longint'(p * 1000), longint'(2 * TCLK * 1000));
   endtask

   task automatic t_all_ratios;
      realtime p, half_fast;
      int cur = 1;
      for (int i = 0; i < 8; i++) begin
         int nxt = (i * 5 + 1) % 8;
         int fast = (nxt < cur) ? nxt : cur;
         half_fast = TCLK / 2.0 * (2.0 ** fast);
         min_w = 1.0e9; primed = 1'b0; mon_on = 1'b1;
         commit_ratio(nxt, TRIM_RST);
         wait_cyc(140); period(p);
         mon_on = 1'b0;
         chk(p == TCLK * (2.0 ** nxt), "R2", $sformatf("period for code %0d ps", nxt),
             longint'(p * 1000), longint'(TCLK * (2.0 ** nxt) * 1000));
         chk(min_w >= half_fast, "R8", $sformatf("narrowest phase %0d->%0d ps", cur, nxt),
             longint'(min_w * 1000), longint'(half_fast * 1000));
         cur = nxt;
      end
   endtask

   task automatic t_trim;
      realtime p;
      wr(12'h020, 32'h003F_0008);
      chk(trim_out == 6'h3F, "R7", "trim_out after write", trim_out, 6'h3F);
      period(p);
      chk(p == 16 * TCLK, "R7", "period with new trim ps", longint'(p * 1000), longint'(16 * TCLK * 1000));
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      wr(12'h020, 32'hFFFF_FFFF);
      rd(12'h020, d);
      chk(d == 32'h003F_000E, "R6", "all-ones write readback", d, 32'h003F_000E);
   endtask

   task automatic t_addr;
      logic [31:0] d; realtime p;
      wr(12'h028, 32'h0000_0002);
      wr(12'h021, 32'h0000_0002);
      rd(12'h020, d);
      chk(d == 32'h003F_000E, "R10", "control word after stray writes", d, 32'h003F_000E);
      wr(12'h025, 32'd0);
      wr(12'h024, 32'd1);
      wait_cyc(300); period(p);
      chk(p == 16 * TCLK, "R10", "period after misaligned arm ps", longint'(p * 1000), longint'(16 * TCLK * 1000));
   endtask

   task automatic t_alive;
      int r0;
      commit_ratio(7, 6'h3F);
      wait_cyc(140);
      r0 = rises;
      wait_cyc(2000);
      chk((rises - r0) >= 15, "R9", "rising edges in 2000 cycles", rises - r0, 15);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #800000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      @(negedge clk); rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_pending();
      t_bare_one();
      t_commit();
      t_second_one();
      t_all_ratios();
      t_trim();
      t_reserved();
      t_addr();
      t_alive();
      finish_run();
   end
endmodule